// File: doc/BRIEF.md
# Response Drain Engine for a Byte-FIFO Security Device

This block is a bus master that collects one complete response from a security device. The device exposes its response through a single-byte data FIFO register. A status register reports when data is present. Two bytes next to the status register report how many FIFO bytes may be read back to back. After a `start` pulse the engine polls status until both the valid and data-present flags are set. It then reads the 16-bit transfer allowance, low byte first, and pulls at most that many bytes before it polls again. Each byte goes out on a valid/ready byte stream as soon as it has been read.

The first six bytes form the fixed part of the response header. Bytes 2 to 5 carry the total response length, including the header, most significant byte first. Once the sixth byte has been taken, the engine checks that length against the caller limit `maxLen` and then fetches the rest. At the end it polls status for valid and checks that no unread data remains. It then writes the command-ready code to status and the active-locality code to the access register, which releases locality 0. A one-cycle `done` pulse reports the result and the number of bytes delivered.

Top module: `tis_resp_reader`

## Requirements
- R1: Before each burst the engine reads status at `STS_ADDR` and continues only when bit 7 (valid) and bit 4 (data present) are both 1; the other status bits are ignored. After `POLL_LIMIT` failed status reads it ends with result 1 (timeout).
- R2: The transfer allowance is read with two single-byte reads: the low byte at `STS_ADDR`+1, then the high byte at `STS_ADDR`+2. No other read is made for it.
- R3: If the allowance reads as zero, both bytes are read again. After `BURST_LIMIT` zero results the engine ends with result 1 (timeout) and delivers no further bytes.
- R4: Between two status reads the number of FIFO reads at `DATA_ADDR` is at most the allowance. In total the engine reads exactly as many FIFO bytes as it delivers.
- R5: The header phase takes exactly 6 bytes. The length is {byte2, byte3, byte4, byte5}, and the engine delivers that many bytes in total.
- R6: If the length is below 6 or above `maxLen`, the engine stops after the sixth byte with result 2 (bad length).
- R7: Bytes leave on `outData` in FIFO order. While `outValid` is high and `outReady` is low, `outData` and `outLast` hold.
- R8: `outLast` is set on the final byte of a response whose length was accepted, and on no other byte. It is never set when the result is 2.
- R9: At the end the engine polls status until valid. If data present is still set and no earlier error occurred, the result is 3 (leftover). An earlier error code is kept.
- R10: Every run, whatever its result, ends with exactly two writes: 0x40 to `STS_ADDR`, then 0x20 to `ACC_ADDR`.
- R11: `done` is high for one cycle. At that cycle `doneCode` holds the result (0 means success) and `doneCount` holds the number of bytes delivered.
- R12: During reset no request is made, `outValid` is low and `done` is low.
- R13: A register request holds its address, direction and write data until `regAck`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin draining one response (sampled while idle) |
| maxLen | input | CNT_W | Largest accepted response length in bytes |
| regReq | output | 1 | Register access request |
| regWe | output | 1 | 1 for a write, 0 for a read |
| regAddr | output | ADDR_W | Byte address of the access |
| regWdata | output | 8 | Write data |
| regAck | input | 1 | Access complete; read data valid |
| regRdata | input | 8 | Read data |
| outValid | output | 1 | Stream byte present |
| outReady | input | 1 | Sink accepts the byte |
| outData | output | 8 | Stream byte |
| outLast | output | 1 | Final byte of the response |
| done | output | 1 | One-cycle completion pulse |
| doneCode | output | 2 | 0 ok, 1 timeout, 2 bad length, 3 leftover |
| doneCount | output | CNT_W | Bytes delivered |

## Verification
The assertions assume the register port acknowledges only an open request, once per request, and returns read data in the cycle of `regAck`. The bench device model enforces this by acknowledging in the cycle after it sees an unacknowledged request. The assertions also assume `start` is only honoured while idle, and the bench pulses it only between runs. The model supplies deliberately awkward conditions: stray low status bits, initial status stalls, runs of zero allowance and surplus FIFO bytes. These stress the response handling without breaking the bus rules.

// File: rtl/tisrd_pkg.sv
package tisrd_pkg;

  // fixed part of the response header that carries the length field
  localparam int HDR_MIN = 6;

  // status and access register bit positions decoded by the device
  localparam int STS_VALID_BIT  = 7;
  localparam int STS_CMDRDY_BIT = 6;
  localparam int STS_DAVAIL_BIT = 4;
  localparam int ACC_ACTIVE_BIT = 5;

  typedef enum logic [1:0] {
    RES_OK       = 2'd0,
    RES_TIMEOUT  = 2'd1,
    RES_BADLEN   = 2'd2,
    RES_LEFTOVER = 2'd3
  } res_e;

  typedef enum logic [2:0] {
    BUS_STS,
    BUS_BLO,
    BUS_BHI,
    BUS_DATA,
    BUS_WRDY,
    BUS_WREL
  } bus_e;

  // strobes from control to datapath
  typedef struct packed {
    logic init;
    logic pollClr;
    logic pollInc;
    logic triesClr;
    logic triesInc;
    logic burstLoLd;
    logic burstHiLd;
    logic byteLd;
    logic bytePush;
    logic setCode;
    res_e codeVal;
    bus_e busSel;
  } ctrl_t;

  // conditions from datapath to control
  typedef struct packed {
    logic stsReady;
    logic stsValid;
    logic stsDavail;
    logic pollExpired;
    logic burstZero;
    logic triesExpired;
    logic headerEnd;
    logic lenOk;
    logic remNextZero;
    logic burstLast;
    logic codeOk;
  } flag_t;

endpackage

// File: rtl/tisrd_datapath.sv
module tisrd_datapath
  import tisrd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STS_ADDR  = 'h18,
  parameter logic [ADDR_W-1:0] ACC_ADDR  = 'h00,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 'h24,
  parameter int CNT_W = 16,
  parameter int POLL_LIMIT = 16,
  parameter int BURST_LIMIT = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  maxLen,
  input  logic [7:0]        regRdata,
  input  ctrl_t             ctl,
  output flag_t             flags,
  output logic [ADDR_W-1:0] regAddr,
  output logic              regWe,
  output logic [7:0]        regWdata,
  output logic [7:0]        outData,
  output logic              outLast,
  output res_e              code,
  output logic [CNT_W-1:0]  count
);

  localparam int POLL_W = $clog2(POLL_LIMIT) + 1;
  localparam int TRY_W  = $clog2(BURST_LIMIT) + 1;
  localparam logic [CNT_W-1:0] HDR_LEN  = CNT_W'(HDR_MIN);
  localparam logic [CNT_W-1:0] LEN_LO   = CNT_W'(2);
  localparam logic [CNT_W-1:0] LEN_HI   = CNT_W'(HDR_MIN - 1);

  logic [CNT_W-1:0]  cnt, remaining, remNext, lenLow;
  logic [15:0]       burstLeft;
  logic [7:0]        burstLo, byteReg;
  logic [31:0]       lenReg;
  logic [POLL_W-1:0] pollCnt;
  logic [TRY_W-1:0]  triesCnt;
  res_e              codeReg;

  assign lenLow  = lenReg[CNT_W-1:0];
  assign remNext = flags.headerEnd ? (lenLow - HDR_LEN) : (remaining - 1'b1);

  always_comb begin
    flags.stsValid     = regRdata[STS_VALID_BIT];
    flags.stsDavail    = regRdata[STS_DAVAIL_BIT];
    flags.stsReady     = regRdata[STS_VALID_BIT] & regRdata[STS_DAVAIL_BIT];
    flags.pollExpired  = (pollCnt == POLL_W'(POLL_LIMIT - 1));
    flags.burstZero    = ({regRdata, burstLo} == 16'd0);
    flags.triesExpired = (triesCnt == TRY_W'(BURST_LIMIT - 1));
    flags.headerEnd    = (cnt == LEN_HI);
    flags.lenOk        = (lenReg[31:CNT_W] == '0) && (lenLow >= HDR_LEN) && (lenLow <= maxLen);
    flags.remNextZero  = (remNext == '0);
    flags.burstLast    = (burstLeft == 16'd1);
    flags.codeOk       = (codeReg == RES_OK);
  end

  // register port address and data selected by the control strobe
  always_comb begin
    regWe    = 1'b0;
    regWdata = 8'h00;
    unique case (ctl.busSel)
      BUS_STS:  regAddr = STS_ADDR;
      BUS_BLO:  regAddr = STS_ADDR + ADDR_W'(1);
      BUS_BHI:  regAddr = STS_ADDR + ADDR_W'(2);
      BUS_DATA: regAddr = DATA_ADDR;
      BUS_WRDY: begin
        regAddr  = STS_ADDR;
        regWe    = 1'b1;
        regWdata = 8'(1 << STS_CMDRDY_BIT);
      end
      BUS_WREL: begin
        regAddr  = ACC_ADDR;
        regWe    = 1'b1;
        regWdata = 8'(1 << ACC_ACTIVE_BIT);
      end
      default:  regAddr = STS_ADDR;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt       <= '0;
      remaining <= '0;
      burstLeft <= '0;
      burstLo   <= '0;
      byteReg   <= '0;
      lenReg    <= '0;
      pollCnt   <= '0;
      triesCnt  <= '0;
      codeReg   <= RES_OK;
    end else begin
      if (ctl.init) begin
        cnt       <= '0;
        remaining <= HDR_LEN;
        lenReg    <= '0;
      end else if (ctl.bytePush) begin
        cnt       <= cnt + 1'b1;
        remaining <= remNext;
      end

      if (ctl.init || ctl.pollClr) pollCnt <= '0;
      else if (ctl.pollInc)        pollCnt <= pollCnt + 1'b1;

      if (ctl.init || ctl.triesClr) triesCnt <= '0;
      else if (ctl.triesInc)        triesCnt <= triesCnt + 1'b1;

      if (ctl.burstLoLd) burstLo <= regRdata;

      if (ctl.burstHiLd)     burstLeft <= {regRdata, burstLo};
      else if (ctl.bytePush) burstLeft <= burstLeft - 1'b1;

      if (ctl.byteLd) begin
        byteReg <= regRdata;
        if (cnt >= LEN_LO && cnt <= LEN_HI) lenReg <= {lenReg[23:0], regRdata};
      end

      if (ctl.init)         codeReg <= RES_OK;
      else if (ctl.setCode) codeReg <= ctl.codeVal;
    end
  end

  // the length is complete once byte 5 is held; last means nothing remains after this byte
  assign outLast = (cnt >= LEN_HI) && flags.lenOk && flags.remNextZero;
  assign outData = byteReg;
  assign code    = codeReg;
  assign count   = cnt;

endmodule

// File: rtl/tisrd_ctrl.sv
module tisrd_ctrl
  import tisrd_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  start,
  input  logic  regAck,
  input  logic  outReady,
  input  flag_t flags,
  output ctrl_t ctl,
  output logic  regReq,
  output logic  outValid,
  output logic  done
);

  typedef enum logic [3:0] {
    S_IDLE, S_POLL, S_BLO, S_BHI, S_RDATA, S_PUSH, S_FIN, S_WRDY, S_WREL, S_DONE
  } state_e;

  state_e state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    ctl         = '0;
    ctl.codeVal = RES_OK;
    ctl.busSel  = BUS_STS;
    stateNext   = state;
    regReq      = 1'b0;
    outValid    = 1'b0;
    done        = 1'b0;

    unique case (state)
      S_IDLE: begin
        if (start) begin
          ctl.init  = 1'b1;
          stateNext = S_POLL;
        end
      end

      S_POLL: begin
        regReq     = 1'b1;
        ctl.busSel = BUS_STS;
        if (regAck) begin
          if (flags.stsReady) begin
            ctl.pollClr  = 1'b1;
            ctl.triesClr = 1'b1;
            stateNext    = S_BLO;
          end else if (flags.pollExpired) begin
            ctl.setCode = 1'b1;
            ctl.codeVal = RES_TIMEOUT;
            stateNext   = S_FIN;
          end else begin
            ctl.pollInc = 1'b1;
          end
        end
      end

      S_BLO: begin
        regReq     = 1'b1;
        ctl.busSel = BUS_BLO;
        if (regAck) begin
          ctl.burstLoLd = 1'b1;
          stateNext     = S_BHI;
        end
      end

      S_BHI: begin
        regReq     = 1'b1;
        ctl.busSel = BUS_BHI;
        if (regAck) begin
          if (!flags.burstZero) begin
            ctl.burstHiLd = 1'b1;
            stateNext     = S_RDATA;
          end else if (flags.triesExpired) begin
            ctl.setCode = 1'b1;
            ctl.codeVal = RES_TIMEOUT;
            stateNext   = S_FIN;
          end else begin
            ctl.triesInc = 1'b1;
            stateNext    = S_BLO;
          end
        end
      end

      S_RDATA: begin
        regReq     = 1'b1;
        ctl.busSel = BUS_DATA;
        if (regAck) begin
          ctl.byteLd = 1'b1;
          stateNext  = S_PUSH;
        end
      end

      S_PUSH: begin
        outValid = 1'b1;
        if (outReady) begin
          ctl.bytePush = 1'b1;
          if (flags.headerEnd && !flags.lenOk) begin
            ctl.setCode = 1'b1;
            ctl.codeVal = RES_BADLEN;
            stateNext   = S_FIN;
          end else if (flags.remNextZero) begin
            stateNext = S_FIN;
          end else if (flags.burstLast) begin
            stateNext = S_POLL;
          end else begin
            stateNext = S_RDATA;
          end
        end
      end

      S_FIN: begin
        regReq     = 1'b1;
        ctl.busSel = BUS_STS;
        if (regAck) begin
          if (flags.stsValid) begin
            if (flags.stsDavail && flags.codeOk) begin
              ctl.setCode = 1'b1;
              ctl.codeVal = RES_LEFTOVER;
            end
            stateNext = S_WRDY;
          end else if (flags.pollExpired) begin
            if (flags.codeOk) begin
              ctl.setCode = 1'b1;
              ctl.codeVal = RES_TIMEOUT;
            end
            stateNext = S_WRDY;
          end else begin
            ctl.pollInc = 1'b1;
          end
        end
      end

      S_WRDY: begin
        regReq     = 1'b1;
        ctl.busSel = BUS_WRDY;
        if (regAck) stateNext = S_WREL;
      end

      S_WREL: begin
        regReq     = 1'b1;
        ctl.busSel = BUS_WREL;
        if (regAck) stateNext = S_DONE;
      end

      S_DONE: begin
        done      = 1'b1;
        stateNext = S_IDLE;
      end

      default: stateNext = S_IDLE;
    endcase

    // the closing status poll starts with a fresh poll budget
    if (stateNext == S_FIN && state != S_FIN) ctl.pollClr = 1'b1;
  end

endmodule

// File: rtl/tis_resp_reader.sv
module tis_resp_reader
  import tisrd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STS_ADDR  = 'h18,
  parameter logic [ADDR_W-1:0] ACC_ADDR  = 'h00,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 'h24,
  parameter int CNT_W = 16,
  parameter int POLL_LIMIT = 16,
  parameter int BURST_LIMIT = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [CNT_W-1:0]  maxLen,
  output logic              regReq,
  output logic              regWe,
  output logic [ADDR_W-1:0] regAddr,
  output logic [7:0]        regWdata,
  input  logic              regAck,
  input  logic [7:0]        regRdata,
  output logic              outValid,
  input  logic              outReady,
  output logic [7:0]        outData,
  output logic              outLast,
  output logic              done,
  output logic [1:0]        doneCode,
  output logic [CNT_W-1:0]  doneCount
);

  ctrl_t ctl;
  flag_t flags;
  res_e  code;

  tisrd_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .regAck   (regAck),
    .outReady (outReady),
    .flags    (flags),
    .ctl      (ctl),
    .regReq   (regReq),
    .outValid (outValid),
    .done     (done)
  );

  tisrd_datapath #(
    .ADDR_W      (ADDR_W),
    .STS_ADDR    (STS_ADDR),
    .ACC_ADDR    (ACC_ADDR),
    .DATA_ADDR   (DATA_ADDR),
    .CNT_W       (CNT_W),
    .POLL_LIMIT  (POLL_LIMIT),
    .BURST_LIMIT (BURST_LIMIT)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .maxLen   (maxLen),
    .regRdata (regRdata),
    .ctl      (ctl),
    .flags    (flags),
    .regAddr  (regAddr),
    .regWe    (regWe),
    .regWdata (regWdata),
    .outData  (outData),
    .outLast  (outLast),
    .code     (code),
    .count    (doneCount)
  );

  assign doneCode = code;

endmodule

// File: rtl/tisrd_check.sv
module tisrd_check #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STS_ADDR  = 'h18,
  parameter logic [ADDR_W-1:0] ACC_ADDR  = 'h00,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 'h24
) (
  input logic              clk,
  input logic              rstN,
  input logic              regReq,
  input logic              regAck,
  input logic              regWe,
  input logic [ADDR_W-1:0] regAddr,
  input logic [7:0]        regWdata,
  input logic              outValid,
  input logic              outReady,
  input logic [7:0]        outData,
  input logic              outLast,
  input logic              done
);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    regReq && !regAck |=> regReq && $stable(regAddr) && $stable(regWe) && $stable(regWdata)); // R13

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData) && $stable(outLast)); // R7

  AST_STREAM_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !regReq); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R11

  AST_READ_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    regReq && !regWe |-> (regAddr == STS_ADDR) || (regAddr == STS_ADDR + ADDR_W'(1)) ||
                         (regAddr == STS_ADDR + ADDR_W'(2)) || (regAddr == DATA_ADDR)); // R2

  AST_WRITE_VAL: assert property (@(posedge clk) disable iff (!rstN)
    regReq && regWe |-> (regAddr == STS_ADDR && regWdata == 8'h40) ||
                        (regAddr == ACC_ADDR && regWdata == 8'h20)); // R10

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rstN |=> !regReq && !outValid && !done); // R12

endmodule

bind tis_resp_reader tisrd_check #(
  .ADDR_W    (ADDR_W),
  .STS_ADDR  (STS_ADDR),
  .ACC_ADDR  (ACC_ADDR),
  .DATA_ADDR (DATA_ADDR)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .regReq   (regReq),
  .regAck   (regAck),
  .regWe    (regWe),
  .regAddr  (regAddr),
  .regWdata (regWdata),
  .outValid (outValid),
  .outReady (outReady),
  .outData  (outData),
  .outLast  (outLast),
  .done     (done)
);

// File: tb/tis_resp_reader_test.sv
`timescale 1ns/1ps
module tis_resp_reader_test;

  localparam logic [7:0] STS  = 8'h18;
  localparam logic [7:0] ACC  = 8'h00;
  localparam logic [7:0] DATA = 8'h24;

  typedef struct packed {
    logic [31:0] len;
    logic [7:0]  resp;
    logic [15:0] maxLen;
    logic [15:0] burst;
    logic [7:0]  zeros;
    logic [7:0]  stall;
    logic [1:0]  rdyMode;
    logic [1:0]  code;
    logic [15:0] count;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    '{32'd10, 8'd10, 16'd64, 16'd4,      8'd0, 8'd0,   2'd0, 2'd0, 16'd10}, // R5 R4 basic, bursts of 4
    '{32'd20, 8'd20, 16'd64, 16'd1,      8'd0, 8'd3,   2'd1, 2'd0, 16'd20}, // R1 stalls, R7 backpressure
    '{32'd6,  8'd6,  16'd64, 16'd16,     8'd0, 8'd0,   2'd0, 2'd0, 16'd6},  // R8 last on header byte
    '{32'd33, 8'd33, 16'd32, 16'd8,      8'd0, 8'd0,   2'd0, 2'd2, 16'd6},  // R6 above limit, R9 code kept
    '{32'd12, 8'd15, 16'd64, 16'd5,      8'd0, 8'd0,   2'd2, 2'd3, 16'd12}, // R9 leftover data
    '{32'd4,  8'd8,  16'd64, 16'd3,      8'd0, 8'd0,   2'd0, 2'd2, 16'd6},  // R6 below header
    '{32'd40, 8'd40, 16'd40, 16'h0100,   8'd0, 8'd0,   2'd0, 2'd0, 16'd40}, // R2 high byte, R6 at limit
    '{32'd14, 8'd14, 16'd64, 16'h0002,   8'd0, 8'd0,   2'd1, 2'd0, 16'd14}, // R2 low byte order
    '{32'd16, 8'd16, 16'd64, 16'd7,      8'd3, 8'd0,   2'd1, 2'd0, 16'd16}, // R3 zero retries
    '{32'd16, 8'd16, 16'd64, 16'd7,      8'd8, 8'd0,   2'd0, 2'd1, 16'd0},  // R3 allowance timeout
    '{32'd10, 8'd10, 16'd64, 16'd4,      8'd0, 8'd255, 2'd0, 2'd1, 16'd0}   // R1 status timeout
  };

  logic        clk = 1'b0;
  logic        rstN;
  logic        start;
  logic [15:0] maxLen;
  logic        regReq, regWe, regAck;
  logic [7:0]  regAddr, regWdata, regRdata;
  logic        outValid, outReady, outData_unused;
  logic [7:0]  outData;
  logic        outLast, done;
  logic [1:0]  doneCode;
  logic [15:0] doneCount;

  always #2 clk = ~clk;

  tis_resp_reader uut (
    .clk(clk), .rstN(rstN), .start(start), .maxLen(maxLen),
    .regReq(regReq), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regAck(regAck), .regRdata(regRdata),
    .outValid(outValid), .outReady(outReady), .outData(outData), .outLast(outLast),
    .done(done), .doneCode(doneCode), .doneCount(doneCount)
  );

  assign outData_unused = 1'b0;

  // device model configuration, written only by the stimulus
  logic        armCase;
  logic [31:0] cfgLen;
  logic [7:0]  cfgResp, cfgZeros, cfgStall;
  logic [15:0] cfgBurst;

  // device model state, written only by the model
  logic [7:0]  rdPtr, stallLeft, zeroLeft;
  logic [15:0] sincePoll, burstViol, dataReads;
  logic [3:0]  wrIdx;
  logic [15:0] wrLog [4];
  logic [7:0]  stsByte;

  function automatic logic [7:0] mkByte(input int idx, input logic [31:0] len);
    case (idx)
      2: return len[31:24];
      3: return len[23:16];
      4: return len[15:8];
      5: return len[7:0];
      default: return 8'(idx * 13 + 7);
    endcase
  endfunction

  // stray low bits are set so that the status mask is exercised
  assign stsByte = {stallLeft == 8'd0, 2'b00, (stallLeft == 8'd0) && (rdPtr < cfgResp), 4'hA};

  always @(posedge clk) begin
    if (!rstN || armCase) begin
      regAck    <= 1'b0;
      regRdata  <= 8'h00;
      rdPtr     <= 8'd0;
      stallLeft <= cfgStall;
      zeroLeft  <= cfgZeros;
      sincePoll <= 16'd0;
      burstViol <= 16'd0;
      dataReads <= 16'd0;
      wrIdx     <= 4'd0;
    end else begin
      regAck <= regReq && !regAck;
      if (regReq && !regAck) begin
        if (regWe) begin
          if (wrIdx < 4'd4) wrLog[wrIdx[1:0]] <= {regAddr, regWdata};
          wrIdx <= wrIdx + 4'd1;
        end else if (regAddr == STS) begin
          regRdata  <= stsByte;
          sincePoll <= 16'd0;
          if (stallLeft != 8'd0) stallLeft <= stallLeft - 8'd1;
        end else if (regAddr == STS + 8'd1) begin
          regRdata <= (zeroLeft != 8'd0) ? 8'h00 : cfgBurst[7:0];
        end else if (regAddr == STS + 8'd2) begin
          regRdata <= (zeroLeft != 8'd0) ? 8'h00 : cfgBurst[15:8];
          if (zeroLeft != 8'd0) zeroLeft <= zeroLeft - 8'd1;
        end else if (regAddr == DATA) begin
          regRdata  <= (rdPtr < cfgResp) ? mkByte(int'(rdPtr), cfgLen) : 8'h00;
          rdPtr     <= rdPtr + 8'd1;
          dataReads <= dataReads + 16'd1;
          sincePoll <= sincePoll + 16'd1;
          if (sincePoll >= cfgBurst) burstViol <= burstViol + 16'd1;
        end
      end
    end
  end

  int nChecks = 0;
  int nFail   = 0;
  int cyc     = 0;

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic runVec(input int n, input vec_t v);
    int  rx = 0;
    int  lastAt = -1;
    int  byteBad = 0;
    bit  seen = 1'b0;
    logic [1:0]  gotCode = '0;
    logic [15:0] gotCount = '0;
    bit  lastOk;
    lastOk = (v.code == 2'd0) || (v.code == 2'd3);
    cfgLen = v.len; cfgResp = v.resp; cfgBurst = v.burst;
    cfgZeros = v.zeros; cfgStall = v.stall; maxLen = v.maxLen;
    armCase = 1'b1;
    @(negedge clk);
    armCase = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < 6000 && !seen; c++) begin
      @(negedge clk);
      cyc++;
      case (v.rdyMode)
        2'd1:    outReady = cyc[0];
        2'd2:    outReady = (cyc % 3) == 0;
        default: outReady = 1'b1;
      endcase
      if (outValid && outReady) begin
        if (outData != mkByte(rx, v.len)) begin
          byteBad++;
          $display("FAIL R7 vec %0d byte %0d: actual %0h expected %0h", n, rx, outData, mkByte(rx, v.len));
        end
        if (outLast) lastAt = rx;
        rx++;
      end
      if (done) begin
        seen = 1'b1;
        gotCode = doneCode;
        gotCount = doneCount;
      end
    end
    if (byteBad != 0) nFail++;
    nChecks++;
    check(seen, $sformatf("R11 vec %0d done within watchdog", n), seen, 1);
    check(gotCode == v.code, $sformatf("R11 vec %0d result code", n), gotCode, v.code);
    check(gotCount == v.count, $sformatf("R11 vec %0d byte count", n), gotCount, v.count);
    check(rx == int'(v.count), $sformatf("R5 vec %0d bytes streamed", n), rx, v.count);
    check(lastAt == (lastOk ? int'(v.count) - 1 : -1),
          $sformatf("R8 vec %0d last flag position", n), lastAt, lastOk ? int'(v.count) - 1 : -1);
    check(dataReads == v.count, $sformatf("R4 vec %0d FIFO reads", n), dataReads, v.count);
    check(burstViol == 16'd0, $sformatf("R4 vec %0d reads beyond allowance", n), burstViol, 0);
    check(wrIdx == 4'd2, $sformatf("R10 vec %0d write count", n), wrIdx, 2);
    check(wrLog[0] == {STS, 8'h40}, $sformatf("R10 vec %0d first write", n), wrLog[0], {STS, 8'h40});
    check(wrLog[1] == {ACC, 8'h20}, $sformatf("R10 vec %0d second write", n), wrLog[1], {ACC, 8'h20});
  endtask

  initial begin
    rstN = 1'b0; start = 1'b0; outReady = 1'b0; armCase = 1'b0; maxLen = 16'd64;
    cfgLen = '0; cfgResp = '0; cfgBurst = '0; cfgZeros = '0; cfgStall = '0;
    repeat (3) @(negedge clk);
    // R12 quiet outputs while reset is held
    check(!regReq, "R12 request during reset", regReq, 0);
    check(!outValid, "R12 stream valid during reset", outValid, 0);
    check(!done, "R12 done during reset", done, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(!regReq && !done, "R12 idle after reset release", {regReq, done}, 0);

    for (int i = 0; i < NVEC; i++) begin
      runVec(i, VECS[i]);
      repeat (2) @(negedge clk);
    end

    // R13 / R12 directed: a start pulse with reset asserted again mid-run leaves the port quiet
    cfgLen = 32'd10; cfgResp = 8'd10; cfgBurst = 16'd4; cfgZeros = 8'd0; cfgStall = 8'd0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check(!regReq && !outValid && !done, "R12 reset aborts a run", {regReq, outValid, done}, 0);
    rstN = 1'b1;
    @(negedge clk);
    runVec(99, VECS[0]);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule